// File: doc/BRIEF.md
# Serial In-System Programming Sequencer

This block is a hardware master that programs a microcontroller through its serial in-system programming port. A host hands it one request at a time on a valid/ready command port: enter programming mode, read the three-byte signature, erase the whole program memory, or write one 16-bit program word. The block turns each request into four-byte SPI command frames. It drives SCK, MOSI and the active-low target reset itself, and it samples MISO. When the request completes it pulses `done` and reports `err`. A signature read also leaves its result on `rdata`.

Command frames always carry four bytes, and any data the target returns arrives in the last byte slot. Entering programming mode checks that the target echoes the second byte back during the third slot. If the echo is wrong, the block releases the bus, sends one stray clock pulse to slide the target's bit alignment, and tries again. A word write checks each byte by reading it back until it matches. There are two exceptions. A byte equal to the erased value is not written at all. A byte equal to the target's in-progress marker value is not polled; the block waits a fixed time instead. Fixed waits are counted in milliseconds from a clock-frequency parameter.

The command port applies back-pressure only through `cmd_ready`. It is high only while the block is idle, and a request is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. No request is queued. The host must hold `cmd_valid` until it is taken.

Top module: `isp_prog_seq`

## Requirements
- R1: `cmd_ready` is high exactly while the block is idle, and a request is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_op` encodes 0 = enter programming mode, 1 = signature read, 2 = chip erase, 3 = word write.
- R2: `done` is high for one cycle at the end of every request, and `cmd_ready` is high in that same cycle. `err` is valid with `done` and holds until the next request is taken. `err` never rises without `done`.
- R3: SPI runs in mode 0 with the MSB first. SCK idles low and each SCK phase lasts CLK_DIV clocks. MOSI changes only while SCK is low. Every frame has exactly 32 SCK rising edges (four bytes).
- R4: `tgt_rst_n` is high after reset. It goes low when an enter request is taken and stays low until the block is reset. After a settle time the block sends 0xAC 0x53 0xFF 0xFF. The attempt succeeds only if the byte received in the third slot is 0x53, so an aligned target succeeds after exactly 32 SCK rising edges.
- R5: A failed attempt is followed by one extra SCK high pulse while no frame is running, and then by a new attempt. After SYNC_TRIES failed attempts (32 by default) the request ends with `err` = 1, and no pulse follows the last attempt.
- R6: A signature read sends three frames 0x30 0x00 i 0x00 for i = 0, 1, 2. The fourth-slot byte of frame i is placed in `rdata[8i+7:8i]`. `rdata` changes at no other time.
- R7: Chip erase sends 0xAC 0x80 0x00 0x00 and then waits ERASE_MS milliseconds before `done`.
- R8: A word write handles the low byte before the high byte. Its frame is an opcode, the address high byte, the address low byte, and then the data byte. The opcode is 0x40 for the low byte and 0x48 for the high byte.
- R9: A data byte of 0xFF produces no frame at all. A word of 0xFFFF completes within 4 cycles of acceptance.
- R10: After writing a byte other than 0x7F, the block sends read frames (0x20 for low, 0x28 for high, address high, address low, 0xFF) until the fourth-slot byte equals the data. It ends with `err` = 1 after POLL_LIMIT polls (255 by default) without a match.
- R11: After writing a byte of 0x7F, the block sends no read frame and waits PROG_WAIT_MS milliseconds instead.
- R12: If the low byte fails verification, no high-byte frame is sent and the write ends with `err` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle and able to take a request |
| cmd_op | input | 2 | Request code (R1) |
| cmd_addr | input | 16 | Word address for a write |
| cmd_data | input | 16 | Word value for a write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag of the last request |
| rdata | output | 24 | Signature bytes, byte 0 in the low bits |
| spi_sck | output | 1 | Serial clock to the target |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| tgt_rst_n | output | 1 | Active-low target reset |

## Verification
A wrong sequencer state shows up as a wrong count of SCK rising edges at the pins. Each missed or extra retry adds or removes 33 edges. A byte that is skipped by mistake removes a whole frame. A poll count that is off shows up as a wrong number of read frames as soon as the request ends. A fault in the byte shifter or the frame builder corrupts the first frame, so a target model loses sync or stores the wrong data within one request. A fault in the wait counters shows up at the next `done` as a completion time outside its window.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    ISP_ENTER = 2'd0,
    ISP_SIGN  = 2'd1,
    ISP_ERASE = 2'd2,
    ISP_WRITE = 2'd3
  } isp_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_SETTLE, SQ_SYNC, SQ_PHI, SQ_PLO,
    SQ_SIGN, SQ_ERASE, SQ_WAIT, SQ_WSEL, SQ_WPROG, SQ_WPOLL
  } sq_state_e;

  localparam logic [7:0] OPB_SYNC   = 8'hAC;
  localparam logic [7:0] OPB_ECHO   = 8'h53;
  localparam logic [7:0] OPB_WIPE   = 8'h80;
  localparam logic [7:0] OPB_SIGN   = 8'h30;
  localparam logic [7:0] OPB_PROG   = 8'h40;
  localparam logic [7:0] OPB_READ   = 8'h20;
  localparam logic [7:0] OPB_HISEL  = 8'h08;
  localparam logic [7:0] VAL_BLANK  = 8'hFF;
  localparam logic [7:0] VAL_MARK   = 8'h7F;
endpackage

// File: rtl/isp_spi_byte.sv
module isp_spi_byte #(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int unsigned HC_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CLKS - 1);

  logic            busy;
  logic [HC_W-1:0] hc;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic            half_end;

  assign half_end = (hc == HC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hc   <= '0;
      bitn <= '0;
      sh   <= '0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx;
          mosi <= tx[7];
          hc   <= '0;
          bitn <= '0;
          sck  <= 1'b0;
        end
      end else if (!half_end) begin
        hc <= hc + 1'b1;
      end else begin
        hc <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/isp_frame_xfer.sv
module isp_frame_xfer #(
  parameter int unsigned HALF_CLKS = 4,
  parameter int unsigned NBYTES    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [8*NBYTES-1:0]   frame,
  input  logic                  miso,
  output logic                  sck,
  output logic                  mosi,
  output logic                  done,
  output logic [7:0]            echo,
  output logic [7:0]            resp
);
  localparam int unsigned IDX_W = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);
  localparam logic [IDX_W-1:0] IDX_ECHO = IDX_W'(NBYTES - 2);

  logic [8*NBYTES-1:0] fr;
  logic [7:0]          fbytes [NBYTES];
  logic [IDX_W-1:0]    idx;
  logic                busy;
  logic                eng_go;
  logic                eng_done;
  logic [7:0]          eng_rx;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    assign fbytes[g] = fr[8*(NBYTES-1-g) +: 8];
  end

  isp_spi_byte #(.HALF_CLKS(HALF_CLKS)) u_byte (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_go),
    .tx    (fbytes[idx]),
    .miso  (miso),
    .sck   (sck),
    .mosi  (mosi),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr     <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      eng_go <= 1'b0;
      done   <= 1'b0;
      echo   <= '0;
      resp   <= '0;
    end else begin
      eng_go <= 1'b0;
      done   <= 1'b0;
      if (!busy) begin
        if (start) begin
          fr     <= frame;
          idx    <= '0;
          busy   <= 1'b1;
          eng_go <= 1'b1;
        end
      end else if (eng_done) begin
        if (idx == IDX_ECHO) echo <= eng_rx;
        if (idx == IDX_LAST) begin
          resp <= eng_rx;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx    <= idx + 1'b1;
          eng_go <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/isp_wait_timer.sv
module isp_wait_timer #(
  parameter int unsigned LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= (len == '0) ? LEN_W'(1) : len;
        run <= 1'b1;
      end else if (run) begin
        if (cnt <= LEN_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/isp_prog_seq.sv
module isp_prog_seq
  import isp_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 4,
  parameter int unsigned CLKS_PER_MS  = 50000,
  parameter int unsigned SYNC_TRIES   = 32,
  parameter int unsigned POLL_LIMIT   = 255,
  parameter int unsigned ERASE_MS     = 25,
  parameter int unsigned PROG_WAIT_MS = 10,
  parameter int unsigned SETTLE_CLKS  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [15:0] cmd_addr,
  input  logic [15:0] cmd_data,
  output logic        done,
  output logic        err,
  output logic [23:0] rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        tgt_rst_n
);
  localparam int unsigned TRY_W  = $clog2(SYNC_TRIES + 1);
  localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int unsigned TM_W   = 32;
  localparam logic [TM_W-1:0] LEN_ERASE  = TM_W'(ERASE_MS * CLKS_PER_MS);
  localparam logic [TM_W-1:0] LEN_PROG   = TM_W'(PROG_WAIT_MS * CLKS_PER_MS);
  localparam logic [TM_W-1:0] LEN_SETTLE = TM_W'(SETTLE_CLKS);
  localparam logic [TM_W-1:0] LEN_PULSE  = TM_W'(CLK_DIV);
  localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(SYNC_TRIES - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [31:0] FR_SYNC  = {OPB_SYNC, OPB_ECHO, VAL_BLANK, VAL_BLANK};
  localparam logic [31:0] FR_ERASE = {OPB_SYNC, OPB_WIPE, 8'h00, 8'h00};

  sq_state_e         state;
  logic [15:0]       addr_q;
  logic [15:0]       data_q;
  logic              half_q;
  logic [TRY_W-1:0]  tries;
  logic [POLL_W-1:0] polls;
  logic [1:0]        sig_idx;
  logic [23:0]       sig_q;
  logic              err_q;
  logic              done_q;
  logic              trst_q;
  logic              pulse_q;
  logic              wait_wr;
  logic              fr_start;
  logic [31:0]       fr_word;
  logic              fr_done;
  logic [7:0]        fr_echo;
  logic [7:0]        fr_resp;
  logic              fr_sck;
  logic              tm_start;
  logic [TM_W-1:0]   tm_len;
  logic              tm_done;
  logic [7:0]        cur_byte;
  logic [7:0]        hsel;

  assign cur_byte = half_q ? data_q[15:8] : data_q[7:0];
  assign hsel     = half_q ? OPB_HISEL : 8'h00;

  isp_frame_xfer #(.HALF_CLKS(CLK_DIV), .NBYTES(4)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fr_start),
    .frame (fr_word),
    .miso  (spi_miso),
    .sck   (fr_sck),
    .mosi  (spi_mosi),
    .done  (fr_done),
    .echo  (fr_echo),
    .resp  (fr_resp)
  );

  isp_wait_timer #(.LEN_W(TM_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tm_start),
    .len   (tm_len),
    .done  (tm_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      half_q   <= 1'b0;
      tries    <= '0;
      polls    <= '0;
      sig_idx  <= '0;
      sig_q    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      trst_q   <= 1'b1;
      pulse_q  <= 1'b0;
      wait_wr  <= 1'b0;
      fr_start <= 1'b0;
      fr_word  <= '0;
      tm_start <= 1'b0;
      tm_len   <= '0;
    end else begin
      fr_start <= 1'b0;
      tm_start <= 1'b0;
      done_q   <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            err_q  <= 1'b0;
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            unique case (isp_op_e'(cmd_op))
              ISP_ENTER: begin
                trst_q   <= 1'b0;
                tries    <= '0;
                tm_len   <= LEN_SETTLE;
                tm_start <= 1'b1;
                state    <= SQ_SETTLE;
              end
              ISP_SIGN: begin
                sig_idx  <= '0;
                fr_word  <= {OPB_SIGN, 8'h00, 8'h00, 8'h00};
                fr_start <= 1'b1;
                state    <= SQ_SIGN;
              end
              ISP_ERASE: begin
                fr_word  <= FR_ERASE;
                fr_start <= 1'b1;
                state    <= SQ_ERASE;
              end
              default: begin
                half_q <= 1'b0;
                state  <= SQ_WSEL;
              end
            endcase
          end
        end
        SQ_SETTLE: begin
          if (tm_done) begin
            fr_word  <= FR_SYNC;
            fr_start <= 1'b1;
            state    <= SQ_SYNC;
          end
        end
        SQ_SYNC: begin
          if (fr_done) begin
            if (fr_echo == OPB_ECHO) begin
              done_q <= 1'b1;
              state  <= SQ_IDLE;
            end else if (tries == TRY_LAST) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              state  <= SQ_IDLE;
            end else begin
              tries    <= tries + 1'b1;
              pulse_q  <= 1'b1;
              tm_len   <= LEN_PULSE;
              tm_start <= 1'b1;
              state    <= SQ_PHI;
            end
          end
        end
        SQ_PHI: begin
          if (tm_done) begin
            pulse_q  <= 1'b0;
            tm_start <= 1'b1;
            state    <= SQ_PLO;
          end
        end
        SQ_PLO: begin
          if (tm_done) begin
            fr_word  <= FR_SYNC;
            fr_start <= 1'b1;
            state    <= SQ_SYNC;
          end
        end
        SQ_SIGN: begin
          if (fr_done) begin
            sig_q[{sig_idx, 3'b000} +: 8] <= fr_resp;
            if (sig_idx == 2'd2) begin
              done_q <= 1'b1;
              state  <= SQ_IDLE;
            end else begin
              sig_idx  <= sig_idx + 2'd1;
              fr_word  <= {OPB_SIGN, 8'h00, {6'b0, sig_idx + 2'd1}, 8'h00};
              fr_start <= 1'b1;
            end
          end
        end
        SQ_ERASE: begin
          if (fr_done) begin
            tm_len   <= LEN_ERASE;
            tm_start <= 1'b1;
            wait_wr  <= 1'b0;
            state    <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (tm_done) begin
            if (wait_wr && !half_q) begin
              half_q <= 1'b1;
              state  <= SQ_WSEL;
            end else begin
              done_q <= 1'b1;
              state  <= SQ_IDLE;
            end
          end
        end
        SQ_WSEL: begin
          if (cur_byte == VAL_BLANK) begin
            if (half_q) begin
              done_q <= 1'b1;
              state  <= SQ_IDLE;
            end else begin
              half_q <= 1'b1;
            end
          end else begin
            fr_word  <= {OPB_PROG | hsel, addr_q[15:8], addr_q[7:0], cur_byte};
            fr_start <= 1'b1;
            state    <= SQ_WPROG;
          end
        end
        SQ_WPROG: begin
          if (fr_done) begin
            if (cur_byte == VAL_MARK) begin
              tm_len   <= LEN_PROG;
              tm_start <= 1'b1;
              wait_wr  <= 1'b1;
              state    <= SQ_WAIT;
            end else begin
              polls    <= '0;
              fr_word  <= {OPB_READ | hsel, addr_q[15:8], addr_q[7:0], VAL_BLANK};
              fr_start <= 1'b1;
              state    <= SQ_WPOLL;
            end
          end
        end
        SQ_WPOLL: begin
          if (fr_done) begin
            if (fr_resp == cur_byte) begin
              if (half_q) begin
                done_q <= 1'b1;
                state  <= SQ_IDLE;
              end else begin
                half_q <= 1'b1;
                state  <= SQ_WSEL;
              end
            end else if (polls == POLL_LAST) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              state  <= SQ_IDLE;
            end else begin
              polls    <= polls + 1'b1;
              fr_start <= 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == SQ_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = sig_q;
  assign spi_sck   = fr_sck | pulse_q;
  assign tgt_rst_n = trst_q;
endmodule

// File: rtl/isp_prog_seq_chk.sv
module isp_prog_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        done,
  input logic        err,
  input logic [23:0] rdata,
  input logic        spi_sck,
  input logic        spi_mosi,
  input logic        tgt_rst_n
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !spi_sck); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |=> (!spi_sck || $stable(spi_mosi))); // R3
  AST_TRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |=> !tgt_rst_n); // R4
  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> $stable(rdata)); // R6
endmodule

bind isp_prog_seq isp_prog_seq_chk i_chk (.*);

// File: tb/test_isp_prog_seq.sv
module test_isp_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 1, CPM = 50, TRIES = 32, POLLS = 255, EMS = 25, PMS = 10;
  localparam int BUSYN = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0, cmd_data = '0;
  logic done, err, spi_sck, spi_mosi, spi_miso, tgt_rst_n;
  logic [23:0] rdata;

  isp_prog_seq #(.CLK_DIV(DIV), .CLKS_PER_MS(CPM), .SYNC_TRIES(TRIES), .POLL_LIMIT(POLLS),
                 .ERASE_MS(EMS), .PROG_WAIT_MS(PMS), .SETTLE_CLKS(4)) i_isp_prog_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .done(done), .err(err),
    .rdata(rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .tgt_rst_n(tgt_rst_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, tests = 0, fails = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // target model
  logic [4:0]  m_cnt = '0;
  logic [31:0] m_in = '0;
  logic [7:0]  m_out = '0;
  bit m_prog = 0, m_mute = 0, m_stuck = 0;
  int m_busy = 0, edges = 0, n_wlo = 0, n_whi = 0, n_rd = 0, n_sig = 0, n_erase = 0;
  logic [7:0] m_first = '0, m_ahi = '0;
  logic [7:0] mem_lo [256];
  logic [7:0] mem_hi [256];
  logic [7:0] sigb [3] = '{8'h1E, 8'h95, 8'h0F};

  assign spi_miso = m_mute ? 1'b1 : m_out[7];

  task automatic model_read(input logic [23:0] c, output logic [7:0] r);
    r = 8'h00;
    if (c[23:16] == 8'h30) begin
      n_sig++;
      r = (c[1:0] < 2'd3) ? sigb[c[1:0]] : 8'h00;
    end else if (c[23:16] == 8'h20 || c[23:16] == 8'h28) begin
      n_rd++;
      if (m_stuck || m_busy > 0) begin
        if (m_busy > 0) m_busy--;
        r = 8'h7F;
      end else r = c[19] ? mem_hi[c[7:0]] : mem_lo[c[7:0]];
    end
  endtask

  task automatic model_exec(input logic [31:0] f);
    if (f[31:24] == 8'hAC && f[23:16] == 8'h80) begin
      n_erase++;
      for (int k = 0; k < 256; k++) begin mem_lo[k] = 8'hFF; mem_hi[k] = 8'hFF; end
    end else if (f[31:24] == 8'h40 || f[31:24] == 8'h48) begin
      if (m_first == 8'h00) m_first = f[31:24];
      m_ahi = f[23:16];
      m_busy = BUSYN;
      if (f[27]) begin n_whi++; mem_hi[f[15:8]] = mem_hi[f[15:8]] & f[7:0]; end
      else begin n_wlo++; mem_lo[f[15:8]] = mem_lo[f[15:8]] & f[7:0]; end
    end
  endtask

  always @(posedge spi_sck) begin
    logic [31:0] nin;
    logic [4:0] nc;
    logic [7:0] rb;
    nin = {m_in[30:0], spi_mosi};
    nc = m_cnt + 5'd1;
    m_in = nin;
    m_cnt = nc;
    edges++;
    if (nc[2:0] != 3'd0) m_out = {m_out[6:0], 1'b0};
    else begin
      case (nc[4:3])
        2'd2: if (nin[15:0] == 16'hAC53) begin m_out = 8'h53; m_prog = 1; end else m_out = 8'h00;
        2'd3: begin
          if (m_prog) begin model_read(nin[23:0], rb); m_out = rb; end else m_out = 8'h00;
        end
        2'd0: begin if (m_prog) model_exec(nin); m_out = 8'h00; end
        default: m_out = 8'h00;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                         output bit e, output int dur);
    int t0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1; t0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1 ready low after accept", 32'(cmd_ready), 0);
    while (!done) @(negedge clk);
    chk(cmd_ready, "R2 ready with done", 32'(cmd_ready), 1);
    e = err; dur = cyc - t0;
    @(negedge clk);
    chk(!done && err == e, "R2 done one cycle, err held", {30'd0, done, err}, {31'd0, e});
  endtask

  initial begin
    bit e;
    int dur, e0, r0, wl0, wh0, s0, x0;
    for (int k = 0; k < 256; k++) begin mem_lo[k] = 8'hFF; mem_hi[k] = 8'hFF; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(cmd_ready && !done && !err, "R1 reset idle", {29'd0, cmd_ready, done, err}, 32'h4);
    chk(tgt_rst_n && !spi_sck, "R4 reset target released", {30'd0, tgt_rst_n, spi_sck}, 32'h2);
    chk(rdata == 24'h0, "R6 reset rdata", 32'(rdata), 0);

    // R4/R5: sweep every bit misalignment of the target
    for (int off = 0; off < 32; off++) begin
      int a;
      m_prog = 0; m_cnt = 5'(off); m_out = '0;
      a = (32 - off) % 32;
      e0 = edges;
      run_cmd(2'd0, 16'h0, 16'h0, e, dur);
      chk(!e, "R5 sync recovered", 32'(e), 0);
      chk(edges - e0 == a * 33 + 32, "R5 sck edges per retry", 32'(edges - e0), 32'(a * 33 + 32));
    end
    chk(!tgt_rst_n, "R4 target held in reset", 32'(tgt_rst_n), 0);

    // R5: target never answers
    m_mute = 1; e0 = edges;
    run_cmd(2'd0, 16'h0, 16'h0, e, dur);
    chk(e, "R5 error after all tries", 32'(e), 1);
    chk(edges - e0 == TRIES * 33 - 1, "R5 edges without final pulse", 32'(edges - e0), 32'(TRIES * 33 - 1));
    m_mute = 0; m_cnt = '0; m_prog = 0; e0 = edges;
    run_cmd(2'd0, 16'h0, 16'h0, e, dur);
    chk(!e && edges - e0 == 32, "R4 aligned first-attempt sync", 32'(edges - e0), 32);

    // R6: signature
    s0 = n_sig;
    run_cmd(2'd1, 16'h0, 16'h0, e, dur);
    chk(rdata == 24'h0F951E, "R6 signature bytes", 32'(rdata), 32'h0F951E);
    chk(n_sig - s0 == 3 && !e, "R6 three frames", 32'(n_sig - s0), 3);

    // R7: erase
    mem_lo[5] = 8'h00; mem_hi[9] = 8'h12; x0 = n_erase;
    run_cmd(2'd2, 16'h0, 16'h0, e, dur);
    chk(n_erase - x0 == 1 && mem_lo[5] == 8'hFF && mem_hi[9] == 8'hFF, "R7 erase frame",
        {mem_lo[5], mem_hi[9]}, 16'hFFFF);
    chk(dur >= EMS * CPM + 64 && dur <= EMS * CPM + 100, "R7 erase wait", 32'(dur), 32'(EMS * CPM + 64));
    chk(rdata == 24'h0F951E, "R6 rdata unchanged by erase", 32'(rdata), 32'h0F951E);

    // R8-R11: sweep byte classes of both halves
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        logic [7:0] lo, hi, ix;
        int exp_rd, n7f;
        ix = 8'(8'h10 + 3 * i + j);
        lo = (i == 0) ? 8'hFF : (i == 1) ? 8'h7F : 8'(8'h30 + j);
        hi = (j == 0) ? 8'hFF : (j == 1) ? 8'h7F : 8'(8'h50 + i);
        exp_rd = ((i == 2) ? BUSYN + 1 : 0) + ((j == 2) ? BUSYN + 1 : 0);
        n7f = (i == 1 ? 1 : 0) + (j == 1 ? 1 : 0);
        wl0 = n_wlo; wh0 = n_whi; r0 = n_rd; m_first = 8'h00; m_ahi = 8'h00;
        run_cmd(2'd3, {8'hA5, ix}, {hi, lo}, e, dur);
        chk(!e, "R10 write ok", 32'(e), 0);
        chk(mem_lo[ix] == lo && mem_hi[ix] == hi, "R8 stored word", {mem_hi[ix], mem_lo[ix]}, {hi, lo});
        chk(n_wlo - wl0 == (i != 0 ? 1 : 0) && n_whi - wh0 == (j != 0 ? 1 : 0),
            "R9 blank bytes skipped", 32'((n_wlo - wl0) * 16 + n_whi - wh0),
            32'((i != 0 ? 16 : 0) + (j != 0 ? 1 : 0)));
        chk(n_rd - r0 == exp_rd, "R10 R11 verify polls", 32'(n_rd - r0), 32'(exp_rd));
        chk(dur >= n7f * PMS * CPM, "R11 fixed wait", 32'(dur), 32'(n7f * PMS * CPM));
        if (i != 0 || j != 0)
          chk(m_ahi == 8'hA5 && m_first == ((i != 0) ? 8'h40 : 8'h48), "R8 order and address",
              {m_first, m_ahi}, {((i != 0) ? 8'h40 : 8'h48), 8'hA5});
        else
          chk(dur <= 4, "R9 blank word fast", 32'(dur), 4);
      end
    end

    // R10/R12: verification never matches
    m_stuck = 1; wl0 = n_wlo; wh0 = n_whi; r0 = n_rd;
    run_cmd(2'd3, 16'hA540, 16'h1234, e, dur);
    chk(e, "R10 poll limit error", 32'(e), 1);
    chk(n_rd - r0 == POLLS, "R10 poll count", 32'(n_rd - r0), 32'(POLLS));
    chk(n_wlo - wl0 == 1 && n_whi - wh0 == 0, "R12 high byte not attempted",
        32'(n_whi - wh0), 0);
    m_stuck = 0;
    run_cmd(2'd3, 16'hA541, 16'h5634, e, dur);
    chk(!e, "R2 err cleared by next request", 32'(e), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule